// File: doc/BRIEF.md
# Power Mode and Clock-Gating Controller

This block decides which clocks of a small microcontroller-style system run. Software programs three registers over a simple write/read port: a mode register with idle, power-down and brown-out control bits, a per-peripheral clock-enable register, and the length of the wakeup timer. From these and from the interrupt, wake and brown-out inputs, the block drives registered clock-enable outputs. There is one enable for the processor, one per gateable peripheral, one for the always-on group (watchdog, GPIO, pin routing, system control) and one for the oscillator. It also drives the brown-out detector enable, the brown-out interrupt and the chip reset request.

Idle stops only the processor clock, and any peripheral interrupt or the external interrupt ends it. Power-down stops the oscillator and every clock. Only the external interrupt ends it. The oscillator then restarts, and the wakeup timer holds every clock off for a programmable number of cycles before normal running resumes. Power-down is refused while a USB wake is enabled and USB still needs its clock. The detector enable follows a global-off bit and a power-down-only-off bit. The reset request from the lower detector stage can be masked on its own, without affecting the upper-stage interrupt.

The write port uses a valid/ready handshake. A write is taken on a rising edge where `cfg_valid` and `cfg_ready` are both 1. `cfg_ready` is 1 only while the system runs with no mode change pending. A master that sees it low must hold its write until it rises again. Reads are combinational on `cfg_addr` and are never stalled.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, the mode register is 0, the peripheral enable register is 0 and the wake length register is `WAKE_RST`. The outputs are: `cpu_clk_en`, `aon_clk_en`, `osc_en` and `bod_en` at 1; `periph_clk_en`, `bod_irq` and `chip_rst_req` at 0; `cfg_ready` at 1.
- R2: An accepted write to address 0 with bit 0 = 1 and bit 1 = 0 clears `cpu_clk_en` on the following rising edge. Peripheral, always-on and oscillator enables keep their values.
- R3: In idle, any bit of `irq_periph` or `ext_irq` sampled at 1 on a rising edge sets `cpu_clk_en` on that same edge and clears address-0 bit 0.
- R4: Power-down is entered on the edge after an accepted address-0 write with bit 1 = 1, even if bit 0 is also 1. `osc_en`, `cpu_clk_en`, `aon_clk_en` and every `periph_clk_en` bit then fall together.
- R5: When `usb_wake_en` and `usb_need_clk` are both 1 at the accepting edge, bit 1 of that write is not stored and power-down is not entered. The bits 0, 2, 3 and 4 of the same write are still stored. With either input at 0, power-down is entered.
- R6: In power-down, only `ext_irq` ends the state. `irq_periph` has no effect. `osc_en` rises on the edge that samples `ext_irq`. The other clock enables stay 0 until the wakeup timer expires, and address-0 bits 0 and 1 then read 0.
- R7: Address 2 holds the wakeup length L (`WT_W` bits). Clocks come back L rising edges after the edge that sampled `ext_irq`, and a value of 0 acts as 1.
- R8: Address 1 holds one enable bit per peripheral. `periph_clk_en[i]` equals that bit while running or idle, one edge after it is written. `aon_clk_en` is 1 except in power-down and wake.
- R9: Address-0 bit 3 at 1 forces `bod_en`, `bod_irq` and `chip_rst_req` to 0 from the next edge. Address-0 bit 2 at 1 forces `bod_en` to 0 only during power-down.
- R10: `bod_irq` is `bod_stage1` and `chip_rst_req` is `bod_stage2`, each registered one edge and gated by the detector enable. Address-0 bit 4 at 1 holds `chip_rst_req` at 0 and leaves `bod_irq` unchanged.
- R11: `cfg_ready` is 0 outside running or while a mode bit is pending, and a write offered then changes nothing. Unused bits of addresses 0 to 2 and all of address 3 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Write offered |
| cfg_ready | output | 1 | Write can be accepted this cycle |
| cfg_addr | input | 2 | Register address for write and read |
| cfg_wdata | input | DW | Write data |
| cfg_rdata | output | DW | Read data for `cfg_addr` |
| irq_periph | input | NPERIPH | Enabled peripheral interrupt requests |
| ext_irq | input | 1 | External interrupt / wake request |
| usb_wake_en | input | 1 | USB wake enabled |
| usb_need_clk | input | 1 | USB still requires its clock |
| bod_stage1 | input | 1 | Upper brown-out threshold crossed |
| bod_stage2 | input | 1 | Lower brown-out threshold crossed |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | NPERIPH | Gateable peripheral clock enables |
| aon_clk_en | output | 1 | Always-on group clock enable |
| osc_en | output | 1 | Oscillator run enable |
| bod_en | output | 1 | Brown-out detector enable |
| bod_irq | output | 1 | Brown-out interrupt |
| chip_rst_req | output | 1 | Brown-out chip reset request |

## Verification
The bench drives peripheral interrupts during power-down. A design that wakes on them would raise `osc_en` early. It also writes idle and power-down together and expects power-down, so a design that gave idle priority would leave the peripheral clocks running. It writes power-down with the USB interlock closed and expects no stop, then writes the combined value and expects idle alone. A design that dropped the whole write, or entered power-down anyway, shows a mismatch at once. Wake lengths of 3 and 0 are timed to the edge to catch off-by-one timers. The brown-out tests cover each disable bit both alone and inside power-down, which separates a reset mask that also hides the interrupt, and a power-down-only disable that acts at all times.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2,
    PM_WAKE  = 2'd3
  } pm_state_e;

  localparam int          ADDR_W   = 2;
  localparam logic [1:0]  REG_MODE = 2'd0;
  localparam logic [1:0]  REG_PCLK = 2'd1;
  localparam logic [1:0]  REG_WAKE = 2'd2;

  // mode register bit positions
  localparam int B_IDLE   = 0;
  localparam int B_PDOWN  = 1;
  localparam int B_BODPD  = 2;
  localparam int B_BODOFF = 3;
  localparam int B_RSTOFF = 4;
  localparam int CTRL_W   = 5;

endpackage

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs
  import pwr_mode_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NPERIPH  = 8,
  parameter int WT_W     = 8,
  parameter int WAKE_RST = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DW-1:0]      cfg_wdata,
  input  logic               wr_open,
  input  logic               wake_clr,
  input  logic               usb_block,
  output logic               cfg_ready,
  output logic [DW-1:0]      cfg_rdata,
  output logic               mode_idle,
  output logic               mode_pdown,
  output logic               bod_pd_sel,
  output logic               bod_off,
  output logic               rst_off,
  output logic [NPERIPH-1:0] pen_q,
  output logic [WT_W-1:0]    wake_len
);

  logic wr_fire;
  logic unused_wbits;

  assign unused_wbits = ^cfg_wdata;
  assign cfg_ready    = wr_open & ~mode_idle & ~mode_pdown;
  assign wr_fire      = cfg_valid & cfg_ready;

  // mode bits: a write only lands while running, a wake only clears while stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_idle  <= 1'b0;
      mode_pdown <= 1'b0;
      bod_pd_sel <= 1'b0;
      bod_off    <= 1'b0;
      rst_off    <= 1'b0;
    end else if (wr_fire && cfg_addr == REG_MODE) begin
      mode_idle  <= cfg_wdata[B_IDLE];
      mode_pdown <= cfg_wdata[B_PDOWN] & ~usb_block;
      bod_pd_sel <= cfg_wdata[B_BODPD];
      bod_off    <= cfg_wdata[B_BODOFF];
      rst_off    <= cfg_wdata[B_RSTOFF];
    end else if (wake_clr) begin
      mode_idle  <= 1'b0;
      mode_pdown <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q <= '0;
    end else if (wr_fire && cfg_addr == REG_PCLK) begin
      pen_q <= cfg_wdata[NPERIPH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_len <= WT_W'(WAKE_RST);
    end else if (wr_fire && cfg_addr == REG_WAKE) begin
      wake_len <= cfg_wdata[WT_W-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      REG_MODE: cfg_rdata[CTRL_W-1:0]  = {rst_off, bod_off, bod_pd_sel, mode_pdown, mode_idle};
      REG_PCLK: cfg_rdata[NPERIPH-1:0] = pen_q;
      REG_WAKE: cfg_rdata[WT_W-1:0]    = wake_len;
      default:  cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int WT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_idle,
  input  logic            req_pdown,
  input  logic [WT_W-1:0] wake_len,
  input  logic            ext_irq,
  input  logic            periph_irq_any,
  output pm_state_e       state_q,
  output pm_state_e       state_d,
  output logic            wake_clr
);

  logic [WT_W-1:0] wake_cnt;
  logic [WT_W-1:0] wake_last;

  // a programmed length of zero behaves as one cycle
  assign wake_last = (wake_len == '0) ? '0 : wake_len - WT_W'(1);

  always_comb begin
    state_d  = state_q;
    wake_clr = 1'b0;
    case (state_q)
      PM_RUN: begin
        if (req_pdown)     state_d = PM_PDOWN;   // power-down wins over idle
        else if (req_idle) state_d = PM_IDLE;
      end
      PM_IDLE: begin
        if (ext_irq || periph_irq_any) begin
          state_d  = PM_RUN;
          wake_clr = 1'b1;
        end
      end
      PM_PDOWN: begin
        if (ext_irq) state_d = PM_WAKE;
      end
      PM_WAKE: begin
        if (wake_cnt >= wake_last) begin
          state_d  = PM_RUN;
          wake_clr = 1'b1;
        end
      end
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_d;
  end

  // wakeup timer: counts only while the oscillator has been restarted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     wake_cnt <= '0;
    else if (state_q == PM_PDOWN)   wake_cnt <= '0;
    else if (state_q == PM_WAKE)    wake_cnt <= wake_cnt + WT_W'(1);
  end

endmodule

// File: rtl/pwr_clk_outs.sv
module pwr_clk_outs
  import pwr_mode_pkg::*;
#(
  parameter int NPERIPH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pm_state_e          state_d,
  input  logic [NPERIPH-1:0] pen_q,
  input  logic               bod_pd_sel,
  input  logic               bod_off,
  input  logic               rst_off,
  input  logic               bod_stage1,
  input  logic               bod_stage2,
  output logic               cpu_clk_en,
  output logic [NPERIPH-1:0] periph_clk_en,
  output logic               aon_clk_en,
  output logic               osc_en,
  output logic               bod_en,
  output logic               bod_irq,
  output logic               chip_rst_req
);

  logic bus_live;
  logic det_on;

  assign bus_live = (state_d == PM_RUN) || (state_d == PM_IDLE);
  assign det_on   = ~bod_off & ~((state_d == PM_PDOWN) & bod_pd_sel);

  // every enable is a flop, so it only moves at the reference clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_clk_en   <= 1'b1;
      aon_clk_en   <= 1'b1;
      osc_en       <= 1'b1;
      bod_en       <= 1'b1;
      bod_irq      <= 1'b0;
      chip_rst_req <= 1'b0;
    end else begin
      cpu_clk_en   <= (state_d == PM_RUN);
      aon_clk_en   <= bus_live;
      osc_en       <= (state_d != PM_PDOWN);
      bod_en       <= det_on;
      bod_irq      <= det_on & bod_stage1;
      chip_rst_req <= det_on & bod_stage2 & ~rst_off;
    end
  end

  for (genvar gi = 0; gi < NPERIPH; gi++) begin : g_pclk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) periph_clk_en[gi] <= 1'b0;
      else        periph_clk_en[gi] <= bus_live & pen_q[gi];
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NPERIPH  = 8,
  parameter int WT_W     = 8,
  parameter int WAKE_RST = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic [1:0]         cfg_addr,
  input  logic [DW-1:0]      cfg_wdata,
  output logic [DW-1:0]      cfg_rdata,
  input  logic [NPERIPH-1:0] irq_periph,
  input  logic               ext_irq,
  input  logic               usb_wake_en,
  input  logic               usb_need_clk,
  input  logic               bod_stage1,
  input  logic               bod_stage2,
  output logic               cpu_clk_en,
  output logic [NPERIPH-1:0] periph_clk_en,
  output logic               aon_clk_en,
  output logic               osc_en,
  output logic               bod_en,
  output logic               bod_irq,
  output logic               chip_rst_req
);

  pm_state_e          state_q;
  pm_state_e          state_d;
  logic               wake_clr;
  logic               mode_idle;
  logic               mode_pdown;
  logic               ctl_bodpd;
  logic               ctl_gdis;
  logic               ctl_rdis;
  logic [NPERIPH-1:0] pen_q;
  logic [WT_W-1:0]    wake_len;

  pwr_cfg_regs #(
    .DW(DW), .NPERIPH(NPERIPH), .WT_W(WT_W), .WAKE_RST(WAKE_RST)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .wr_open    (state_q == PM_RUN),
    .wake_clr   (wake_clr),
    .usb_block  (usb_wake_en & usb_need_clk),
    .cfg_ready  (cfg_ready),
    .cfg_rdata  (cfg_rdata),
    .mode_idle  (mode_idle),
    .mode_pdown (mode_pdown),
    .bod_pd_sel (ctl_bodpd),
    .bod_off    (ctl_gdis),
    .rst_off    (ctl_rdis),
    .pen_q      (pen_q),
    .wake_len   (wake_len)
  );

  pwr_mode_fsm #(.WT_W(WT_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_idle       (mode_idle),
    .req_pdown      (mode_pdown),
    .wake_len       (wake_len),
    .ext_irq        (ext_irq),
    .periph_irq_any (|irq_periph),
    .state_q        (state_q),
    .state_d        (state_d),
    .wake_clr       (wake_clr)
  );

  pwr_clk_outs #(.NPERIPH(NPERIPH)) u_outs (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_d       (state_d),
    .pen_q         (pen_q),
    .bod_pd_sel    (ctl_bodpd),
    .bod_off       (ctl_gdis),
    .rst_off       (ctl_rdis),
    .bod_stage1    (bod_stage1),
    .bod_stage2    (bod_stage2),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .aon_clk_en    (aon_clk_en),
    .osc_en        (osc_en),
    .bod_en        (bod_en),
    .bod_irq       (bod_irq),
    .chip_rst_req  (chip_rst_req)
  );

endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk
  import pwr_mode_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NPERIPH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_valid,
  input logic               cfg_ready,
  input logic [1:0]         cfg_addr,
  input logic [DW-1:0]      cfg_wdata,
  input logic [NPERIPH-1:0] irq_periph,
  input logic               ext_irq,
  input logic               usb_wake_en,
  input logic               usb_need_clk,
  input logic               cpu_clk_en,
  input logic [NPERIPH-1:0] periph_clk_en,
  input logic               aon_clk_en,
  input logic               osc_en,
  input logic               bod_en,
  input logic               chip_rst_req,
  input pm_state_e          state_q,
  input logic               ctl_gdis,
  input logic               ctl_rdis,
  input logic [NPERIPH-1:0] pen_q
);

  assert_pdown_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!cpu_clk_en && periph_clk_en == '0 && !aon_clk_en));

  assert_cpu_needs_osc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (osc_en && aon_clk_en));

  assert_usb_interlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready && cfg_addr == REG_MODE && cfg_wdata[B_PDOWN]
     && usb_wake_en && usb_need_clk) |=> ##1 osc_en);

  assert_idle_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE && (ext_irq || irq_periph != '0)) |=> cpu_clk_en);

  assert_pdown_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_PDOWN && !ext_irq) |=> !osc_en);

  assert_bod_global_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_gdis |=> (!bod_en && !chip_rst_req));

  assert_rst_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdis |=> !chip_rst_req);

  assert_periph_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((periph_clk_en & ~$past(pen_q)) == '0));

  assert_ready_run_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PM_RUN) |-> !cfg_ready);

endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.DW(DW), .NPERIPH(NPERIPH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_valid     (cfg_valid),
  .cfg_ready     (cfg_ready),
  .cfg_addr      (cfg_addr),
  .cfg_wdata     (cfg_wdata),
  .irq_periph    (irq_periph),
  .ext_irq       (ext_irq),
  .usb_wake_en   (usb_wake_en),
  .usb_need_clk  (usb_need_clk),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .aon_clk_en    (aon_clk_en),
  .osc_en        (osc_en),
  .bod_en        (bod_en),
  .chip_rst_req  (chip_rst_req),
  .state_q       (state_q),
  .ctl_gdis      (ctl_gdis),
  .ctl_rdis      (ctl_rdis),
  .pen_q         (pen_q)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 32;
  localparam int NP         = 8;
  localparam int WT_W       = 8;
  localparam int WAKE_RST   = 16;
  localparam int WD_LIMIT   = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_valid = 1'b0;
  logic          cfg_ready;
  logic [1:0]    cfg_addr = 2'd0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic [NP-1:0] irq_periph = '0;
  logic          ext_irq = 1'b0;
  logic          usb_wake_en = 1'b0;
  logic          usb_need_clk = 1'b0;
  logic          bod_stage1 = 1'b0;
  logic          bod_stage2 = 1'b0;
  logic          cpu_clk_en;
  logic [NP-1:0] periph_clk_en;
  logic          aon_clk_en;
  logic          osc_en;
  logic          bod_en;
  logic          bod_irq;
  logic          chip_rst_req;

  pwr_mode_ctrl #(.DW(DW), .NPERIPH(NP), .WT_W(WT_W), .WAKE_RST(WAKE_RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_periph(irq_periph), .ext_irq(ext_irq), .usb_wake_en(usb_wake_en),
    .usb_need_clk(usb_need_clk), .bod_stage1(bod_stage1), .bod_stage2(bod_stage2),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .aon_clk_en(aon_clk_en),
    .osc_en(osc_en), .bod_en(bod_en), .bod_irq(bod_irq), .chip_rst_req(chip_rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // m_st: 0 running, 1 idle, 2 powered down, 3 waiting for oscillator
  int     m_st, m_cnt, m_len, m_ns, m_last;
  bit     m_on = 0;
  bit     m_idle, m_pd, m_bodpd, m_gdis, m_rdis, m_acc, m_clr, m_det;
  int     m_pen;
  bit     e_cpu, e_aon, e_osc, e_bod, e_irq, e_rst;
  int     e_per;

  function automatic longint model_read(input int a);
    case (a)
      0: return {m_rdis, m_gdis, m_bodpd, m_pd, m_idle};
      1: return m_pen;
      2: return m_len;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 1; m_st = 0; m_cnt = 0; m_len = WAKE_RST; m_pen = 0;
      m_idle = 0; m_pd = 0; m_bodpd = 0; m_gdis = 0; m_rdis = 0;
      e_cpu = 1; e_aon = 1; e_osc = 1; e_bod = 1; e_irq = 0; e_rst = 0; e_per = 0;
    end else if (m_on) begin
      m_acc  = cfg_valid && m_st == 0 && !m_idle && !m_pd;
      m_last = (m_len == 0) ? 0 : m_len - 1;
      m_clr  = 0;
      m_ns   = m_st;
      if (m_st == 0) begin
        if (m_pd) m_ns = 2; else if (m_idle) m_ns = 1;
      end else if (m_st == 1) begin
        if (ext_irq || irq_periph != 0) begin m_ns = 0; m_clr = 1; end
      end else if (m_st == 2) begin
        if (ext_irq) m_ns = 3;
      end else begin
        if (m_cnt >= m_last) begin m_ns = 0; m_clr = 1; end
      end
      m_det = !m_gdis && !(m_ns == 2 && m_bodpd);
      e_cpu = (m_ns == 0);
      e_aon = (m_ns <= 1);
      e_per = e_aon ? m_pen : 0;
      e_osc = (m_ns != 2);
      e_bod = m_det;
      e_irq = m_det && bod_stage1;
      e_rst = m_det && bod_stage2 && !m_rdis;
      if (m_st == 2) m_cnt = 0; else if (m_st == 3) m_cnt++;
      if (m_acc) begin
        if (cfg_addr == 0) begin
          m_idle = cfg_wdata[0]; m_pd = cfg_wdata[1] && !(usb_wake_en && usb_need_clk);
          m_bodpd = cfg_wdata[2]; m_gdis = cfg_wdata[3]; m_rdis = cfg_wdata[4];
        end else if (cfg_addr == 1) m_pen = cfg_wdata[NP-1:0];
        else if (cfg_addr == 2) m_len = cfg_wdata[WT_W-1:0];
      end
      if (m_clr) begin m_idle = 0; m_pd = 0; end
      m_st = m_ns;
    end
  end

  // compare every output on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && m_on) begin
      chk("R2 cpu_clk_en",    cpu_clk_en,    e_cpu);
      chk("R8 periph_clk_en", periph_clk_en, e_per);
      chk("R8 aon_clk_en",    aon_clk_en,    e_aon);
      chk("R4 osc_en",        osc_en,        e_osc);
      chk("R9 bod_en",        bod_en,        e_bod);
      chk("R10 bod_irq",      bod_irq,       e_irq);
      chk("R10 chip_rst_req", chip_rst_req,  e_rst);
      chk("R11 cfg_ready",    cfg_ready,     (m_st == 0 && !m_idle && !m_pd));
      chk("R11 cfg_rdata",    cfg_rdata,     model_read(cfg_addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=<%0d cycles", cyc, WD_LIMIT);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #2;
    cfg_valid = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_valid = 1'b0; cfg_wdata = '0;
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [1:0] a, input longint exp, input string what);
    @(posedge clk); #2;
    cfg_addr = a;
    @(negedge clk);
    chk(what, cfg_rdata, exp);
  endtask

  task automatic pulse_ext();
    @(posedge clk); #2 ext_irq = 1'b1;
    @(posedge clk); #2 ext_irq = 1'b0;
  endtask

  task automatic pulse_irq(input logic [NP-1:0] b);
    @(posedge clk); #2 irq_periph = b;
    @(posedge clk); #2 irq_periph = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    negs(1);
    chk("R1 reset cpu_clk_en", cpu_clk_en, 1);
    chk("R1 reset periph_clk_en", periph_clk_en, 0);
    chk("R1 reset osc_en", osc_en, 1);
    chk("R1 reset bod_en", bod_en, 1);
    chk("R1 reset chip_rst_req", chip_rst_req, 0);
    rd_chk(2'd0, 0, "R1 reset mode reg");
    rd_chk(2'd2, WAKE_RST, "R1 reset wake len");

    // peripheral gating and wake length
    wr(2'd1, 32'h0000_00A5);
    negs(2);
    chk("R8 periph enables follow register", periph_clk_en, 8'hA5);
    wr(2'd2, 32'd3);
    rd_chk(2'd2, 3, "R7 wake len readback");

    // idle, woken by a peripheral interrupt
    wr(2'd0, 32'h1);
    negs(2);
    chk("R2 idle stops cpu", cpu_clk_en, 0);
    chk("R2 idle keeps periph", periph_clk_en, 8'hA5);
    chk("R2 idle keeps osc", osc_en, 1);
    wr(2'd1, 32'h0000_0000);             // offered while not ready: must be dropped
    negs(3);
    chk("R11 refused write during idle", periph_clk_en, 8'hA5);
    pulse_irq(8'h04);
    negs(1);
    chk("R3 periph irq ends idle", cpu_clk_en, 1);
    rd_chk(2'd0, 0, "R3 idle bit cleared");
    rd_chk(2'd1, 8'hA5, "R11 pen unchanged after refused write");

    // idle, woken by the external interrupt
    wr(2'd0, 32'h1);
    negs(3);
    pulse_ext();
    negs(1);
    chk("R3 ext irq ends idle", cpu_clk_en, 1);

    // power-down, wake length 3
    wr(2'd0, 32'h2);
    negs(2);
    chk("R4 pdown stops osc", osc_en, 0);
    chk("R4 pdown stops aon", aon_clk_en, 0);
    pulse_irq(8'hFF);
    negs(2);
    chk("R6 periph irq ignored in pdown", osc_en, 0);
    pulse_ext();
    negs(1);
    chk("R6 osc restarts on wake", osc_en, 1);
    chk("R6 cpu held during wake", cpu_clk_en, 0);
    negs(2);
    chk("R7 cpu still held at L-1", cpu_clk_en, 0);
    negs(1);
    chk("R7 cpu back after L edges", cpu_clk_en, 1);
    rd_chk(2'd0, 0, "R6 mode bits cleared after wake");

    // both mode bits: power-down wins
    wr(2'd0, 32'h3);
    negs(2);
    chk("R4 pdown priority over idle", periph_clk_en, 0);
    chk("R4 pdown priority osc", osc_en, 0);
    pulse_ext();
    negs(4);
    rd_chk(2'd0, 0, "R6 both bits read 0 after wake");

    // USB interlock
    @(posedge clk); #2 usb_wake_en = 1'b1; usb_need_clk = 1'b1;
    wr(2'd0, 32'h2);
    negs(3);
    chk("R5 pdown refused by usb", osc_en, 1);
    rd_chk(2'd0, 0, "R5 pdown bit not stored");
    wr(2'd0, 32'h3);
    negs(2);
    chk("R5 idle part still taken", cpu_clk_en, 0);
    chk("R5 idle part osc on", osc_en, 1);
    rd_chk(2'd0, 1, "R5 only idle stored");
    pulse_irq(8'h01);
    @(posedge clk); #2 usb_need_clk = 1'b0;
    wr(2'd0, 32'h2);
    negs(2);
    chk("R5 pdown allowed without clock need", osc_en, 0);
    pulse_ext();
    negs(5);
    @(posedge clk); #2 usb_wake_en = 1'b0;

    // wake length 0 behaves as 1
    wr(2'd2, 32'd0);
    wr(2'd0, 32'h2);
    negs(2);
    pulse_ext();
    negs(1);
    chk("R7 len0 first cycle held", cpu_clk_en, 0);
    negs(1);
    chk("R7 len0 back after one edge", cpu_clk_en, 1);

    // brown-out controls
    @(posedge clk); #2 bod_stage1 = 1'b1; bod_stage2 = 1'b1;
    negs(2);
    chk("R10 stage1 irq", bod_irq, 1);
    chk("R10 stage2 reset", chip_rst_req, 1);
    wr(2'd0, 32'h10);
    negs(2);
    chk("R10 reset masked", chip_rst_req, 0);
    chk("R10 irq unaffected by mask", bod_irq, 1);
    wr(2'd0, 32'h08);
    negs(2);
    chk("R9 global off bod_en", bod_en, 0);
    chk("R9 global off irq", bod_irq, 0);
    wr(2'd0, 32'h04);
    negs(2);
    chk("R9 pd-only off inactive while running", bod_en, 1);
    wr(2'd0, 32'h06);
    negs(2);
    chk("R9 detector off in pdown", bod_en, 0);
    chk("R9 no reset with detector off", chip_rst_req, 0);
    pulse_ext();
    negs(3);
    wr(2'd0, 32'h02);
    negs(2);
    chk("R9 detector stays on in pdown", bod_en, 1);
    chk("R9 reset can fire in pdown", chip_rst_req, 1);
    pulse_ext();
    negs(3);
    @(posedge clk); #2 bod_stage1 = 1'b0; bod_stage2 = 1'b0;

    // reserved bits and unused address
    wr(2'd0, 32'hFFFF_FFE0);
    rd_chk(2'd0, 0, "R11 reserved mode bits read 0");
    wr(2'd1, 32'hFFFF_FF3C);
    rd_chk(2'd1, 8'h3C, "R11 upper pen bits dropped");
    wr(2'd3, 32'hFFFF_FFFF);
    rd_chk(2'd3, 0, "R11 address 3 reads 0");
    negs(2);
    chk("R8 new enables applied", periph_clk_en, 8'h3C);

    negs(4);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule